// File: doc/BRIEF.md
# Masked Configuration Latch Bank

This block is a write-only configuration store. A host drives an address, a data byte and an active-low write strobe. On each rising clock edge where the strobe is low, the byte goes into one of sixteen 8-bit latch banks. There is no readback path. Every bank drives its bits straight out as flat vectors that other logic on the chip decodes.

The sixteen banks fall into three groups:

- **Channel banks.** The low addresses, `CHAN_BANKS` of them (twelve by default), hold per-channel settings.
- **Global banks.** Addresses 12, 13 and 14 hold global settings. Two of these bytes also form a per-channel-bank group-enable vector. Bit 0 of address 14 turns on broadcast. With broadcast on, one channel write lands in every channel bank whose group-enable bit is set.
- **Mask bank.** Address 15 holds a mask. For every write except a write to the mask itself, a mask bit of 1 lets the corresponding data bit through and a mask bit of 0 keeps the bank's old bit.

The mask resets to all ones, so masking is off until software loads a different mask.

Top module: `cfg_latch_bank`

## Requirements
- R1: A synchronous active-high reset loads the following defaults, which are visible from the cycle after the reset edge:
  - all channel banks to 00h;
  - address 12 to FFh;
  - address 13 to 0Fh;
  - address 14 to 00h;
  - the mask bank to FFh.
- R2: A bank is written only when `cfg_wr_n` is low at a rising clock edge. The new value appears on the outputs in the following cycle. With `cfg_wr_n` high, no output changes.
- R3: A write to a channel bank or a global bank changes exactly the bit positions where the mask bank holds 1, and those positions take the data bits. Positions where the mask holds 0 keep their previous value.
- R4: A write to address 15 replaces all eight mask bits with the data byte, whatever the mask holds at the time.
- R5: The address map is as follows:
  - address a < `CHAN_BANKS` selects channel bank a, output on `chan_cfg_o[8a+7:8a]`;
  - addresses 12, 13 and 14 select bytes 0, 1 and 2 of `glob_cfg_o`;
  - address 15 selects `mask_o`.
- R6: Broadcast is on while bit 0 of address 14 is 1. In that state, a write to any channel address updates every channel bank i whose group-enable bit i is 1, and no other channel bank.
  - Group-enable bits 7..0 come from address 12.
  - Group-enable bits 11..8 come from bits 3..0 of address 13.
  - With broadcast off, only the addressed channel bank is written.
- R7: Writes to addresses 12 to 15 are never broadcast. With broadcast on, such a write leaves every channel bank unchanged.
- R8: A write to an address from `CHAN_BANKS` to 11 (present only when `CHAN_BANKS` < 12) changes no bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_n | input | 1 | Write strobe, active low |
| cfg_addr | input | 4 | Bank address |
| cfg_data | input | 8 | Write data |
| chan_cfg_o | output | 8*CHAN_BANKS | Channel bank contents, bank i in bits 8i+7..8i |
| glob_cfg_o | output | 24 | Global banks 12, 13, 14 in bytes 0, 1, 2 |
| mask_o | output | 8 | Mask bank contents |

## Verification
The hardest state to reach is a broadcast write that lands under a partial mask while the group-enable vector covers only a few banks. Reaching it takes a fixed order of earlier writes: first the group-enable bytes, then the broadcast bit, and only then the channel write. Each earlier write must itself get through the mask in force when it happens. The stimulus table therefore walks an order that first programs a partial mask, then an all-zero mask, then restores all ones, and only after that sets group enables and broadcast. The channel banks outside the enabled group are then inspected one by one with idle cycles. A second instance built with fewer channel banks supplies the unused addresses.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 4;
    localparam int GLOB_BANKS  = 3;
    localparam int MAX_CHAN    = 12;
    localparam int GLEN_W      = MAX_CHAN;

    localparam logic [ADDR_W-1:0] A_GLEN_LO = 4'd12;
    localparam logic [ADDR_W-1:0] A_GLEN_HI = 4'd13;
    localparam logic [ADDR_W-1:0] A_MISC    = 4'd14;
    localparam logic [ADDR_W-1:0] A_MASK    = 4'd15;

    localparam logic [DATA_W-1:0] RST_CHAN   = 8'h00;
    localparam logic [DATA_W-1:0] RST_GLEN_LO = 8'hFF;
    localparam logic [DATA_W-1:0] RST_GLEN_HI = 8'h0F;
    localparam logic [DATA_W-1:0] RST_MISC   = 8'h00;
    localparam logic [DATA_W-1:0] RST_MASK   = 8'hFF;
endpackage

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
    import cfg_bank_pkg::*;
#(
    parameter int CHAN_BANKS = 12
) (
    input  logic                  wr_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  bcast,
    input  logic [CHAN_BANKS-1:0] glen,
    output logic [CHAN_BANKS-1:0] chan_we,
    output logic [GLOB_BANKS-1:0] glob_we,
    output logic                  mask_we
);
    logic in_chan;

    always_comb begin
        in_chan = !wr_n && (int'(addr) < CHAN_BANKS);
        for (int i = 0; i < CHAN_BANKS; i++) begin
            chan_we[i] = in_chan && (bcast ? glen[i] : (int'(addr) == i));
        end
        glob_we[0] = !wr_n && (addr == A_GLEN_LO);
        glob_we[1] = !wr_n && (addr == A_GLEN_HI);
        glob_we[2] = !wr_n && (addr == A_MISC);
        mask_we    = !wr_n && (addr == A_MASK);
    end

    // R5: at most one of the global/mask banks is selected, and never together with a channel bank
    always_comb begin
        a_r5_single_target: assert ($onehot0({glob_we, mask_we, |chan_we}));
    end

    // R8: gap addresses select nothing
    always_comb begin
        if (int'(addr) >= CHAN_BANKS && int'(addr) < MAX_CHAN)
            a_r8_gap_no_select: assert (chan_we == '0 && glob_we == '0 && !mask_we);
    end
endmodule

// File: rtl/cfg_masked_merge.sv
module cfg_masked_merge
    import cfg_bank_pkg::*;
#(
    parameter bit UNMASKED = 1'b0
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mask,
    input  logic              we,
    output logic [DATA_W-1:0] nxt
);
    generate
        if (UNMASKED) begin : g_plain
            logic unused_mask;
            assign unused_mask = ^mask;
            assign nxt = we ? wdata : cur;
        end else begin : g_masked
            assign nxt = we ? ((cur & ~mask) | (wdata & mask)) : cur;
        end
    endgenerate
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
    import cfg_bank_pkg::*;
#(
    parameter int CHAN_BANKS = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_wr_n,
    input  logic [3:0]                   cfg_addr,
    input  logic [7:0]                   cfg_data,
    output logic [8*CHAN_BANKS-1:0]      chan_cfg_o,
    output logic [8*GLOB_BANKS-1:0]      glob_cfg_o,
    output logic [7:0]                   mask_o
);
    typedef struct packed {
        logic [CHAN_BANKS-1:0][DATA_W-1:0] chan;
        logic [GLOB_BANKS-1:0][DATA_W-1:0] glob;
        logic [DATA_W-1:0]                 mask;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    logic [GLEN_W-1:0]                 glen_all;
    logic [CHAN_BANKS-1:0]             chan_we;
    logic [GLOB_BANKS-1:0]             glob_we;
    logic                              mask_we;
    logic [CHAN_BANKS-1:0][DATA_W-1:0] chan_nxt;
    logic [GLOB_BANKS-1:0][DATA_W-1:0] glob_nxt;
    logic [DATA_W-1:0]                 mask_nxt;
    logic                              unused_glen;

    assign glen_all    = {state_q.glob[1][3:0], state_q.glob[0]};
    assign unused_glen = ^{state_q.glob[1][7:4], glen_all};

    cfg_wr_decode #(.CHAN_BANKS(CHAN_BANKS)) u_dec (
        .wr_n    (cfg_wr_n),
        .addr    (cfg_addr),
        .bcast   (state_q.glob[2][0]),
        .glen    (glen_all[CHAN_BANKS-1:0]),
        .chan_we (chan_we),
        .glob_we (glob_we),
        .mask_we (mask_we)
    );

    generate
        for (genvar g = 0; g < CHAN_BANKS; g++) begin : g_chan
            cfg_masked_merge #(.UNMASKED(1'b0)) u_merge (
                .cur(state_q.chan[g]), .wdata(cfg_data), .mask(state_q.mask),
                .we(chan_we[g]), .nxt(chan_nxt[g])
            );
        end
        for (genvar g = 0; g < GLOB_BANKS; g++) begin : g_glob
            cfg_masked_merge #(.UNMASKED(1'b0)) u_merge (
                .cur(state_q.glob[g]), .wdata(cfg_data), .mask(state_q.mask),
                .we(glob_we[g]), .nxt(glob_nxt[g])
            );
        end
    endgenerate

    cfg_masked_merge #(.UNMASKED(1'b1)) u_mask_merge (
        .cur(state_q.mask), .wdata(cfg_data), .mask(state_q.mask),
        .we(mask_we), .nxt(mask_nxt)
    );

    always_comb begin
        state_d.chan = chan_nxt;
        state_d.glob = glob_nxt;
        state_d.mask = mask_nxt;
        if (rst) begin
            for (int i = 0; i < CHAN_BANKS; i++) state_d.chan[i] = RST_CHAN;
            state_d.glob[0] = RST_GLEN_LO;
            state_d.glob[1] = RST_GLEN_HI;
            state_d.glob[2] = RST_MISC;
            state_d.mask    = RST_MASK;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign chan_cfg_o = state_q.chan;
    assign glob_cfg_o = state_q.glob;
    assign mask_o     = state_q.mask;

    // R4: mask bank takes the whole byte
    a_r4_mask_full_write: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_n && cfg_addr == A_MASK) |=> (mask_o == $past(cfg_data)));

    // R3: masked-off bits of address 12 keep their value, enabled bits take data
    a_r3_kept_bits: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_n && cfg_addr == A_GLEN_LO) |=>
        (((glob_cfg_o[7:0] ^ $past(glob_cfg_o[7:0])) & ~$past(mask_o)) == 8'h00) &&
        (((glob_cfg_o[7:0] ^ $past(cfg_data)) & $past(mask_o)) == 8'h00));

    // R2: idle strobe leaves everything alone
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_n |=> ($stable(chan_cfg_o) && $stable(glob_cfg_o) && $stable(mask_o)));

    // R7: global and mask writes never reach channel banks
    a_r7_no_chan_spill: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_n && cfg_addr >= A_GLEN_LO) |=> $stable(chan_cfg_o));

    // R8: gap addresses leave every bank unchanged
    a_r8_gap_ignored: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_n && int'(cfg_addr) >= CHAN_BANKS && int'(cfg_addr) < MAX_CHAN) |=>
        ($stable(chan_cfg_o) && $stable(glob_cfg_o) && $stable(mask_o)));
endmodule

// File: tb/cfg_latch_bank_tb.sv
module cfg_latch_bank_tb;
    localparam int NCH = 12;
    localparam int NSM = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_n = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] data = '0;
    logic [8*NCH-1:0] chan;
    logic [23:0]      glob;
    logic [7:0]       mask;
    logic [8*NSM-1:0] s_chan;
    logic [23:0]      s_glob;
    logic [7:0]       s_mask;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cfg_latch_bank #(.CHAN_BANKS(NCH)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr_n(wr_n), .cfg_addr(addr), .cfg_data(data),
        .chan_cfg_o(chan), .glob_cfg_o(glob), .mask_o(mask));

    cfg_latch_bank #(.CHAN_BANKS(NSM)) u_small (
        .clk(clk), .rst(rst), .cfg_wr_n(wr_n), .cfg_addr(addr), .cfg_data(data),
        .chan_cfg_o(s_chan), .glob_cfg_o(s_glob), .mask_o(s_mask));

    typedef struct packed {
        logic       wr_n;
        logic [3:0] addr;
        logic [7:0] data;
        logic [3:0] bank;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 4'd0,  8'h5A, 4'd0,  8'h00, 4'd2}, // R2 strobe high
        '{1'b0, 4'd0,  8'h5A, 4'd0,  8'h5A, 4'd5}, // R5
        '{1'b0, 4'd11, 8'hC3, 4'd11, 8'hC3, 4'd5},
        '{1'b0, 4'd13, 8'hA5, 4'd13, 8'hA5, 4'd5},
        '{1'b0, 4'd15, 8'h0F, 4'd15, 8'h0F, 4'd4}, // R4
        '{1'b0, 4'd0,  8'hFF, 4'd0,  8'h5F, 4'd3}, // R3 partial mask
        '{1'b0, 4'd13, 8'h00, 4'd13, 8'hA0, 4'd3}, // R3 on global bank
        '{1'b0, 4'd15, 8'h00, 4'd15, 8'h00, 4'd4}, // R4 despite mask 0F
        '{1'b0, 4'd5,  8'hFF, 4'd5,  8'h00, 4'd3}, // R3 mask all zero
        '{1'b0, 4'd15, 8'hFF, 4'd15, 8'hFF, 4'd4},
        '{1'b0, 4'd12, 8'h03, 4'd12, 8'h03, 4'd5},
        '{1'b0, 4'd13, 8'h08, 4'd13, 8'h08, 4'd5},
        '{1'b0, 4'd14, 8'h01, 4'd14, 8'h01, 4'd5},
        '{1'b0, 4'd7,  8'h3C, 4'd0,  8'h3C, 4'd6}, // R6 broadcast
        '{1'b1, 4'd0,  8'h00, 4'd1,  8'h3C, 4'd6},
        '{1'b1, 4'd0,  8'h00, 4'd11, 8'h3C, 4'd6},
        '{1'b1, 4'd0,  8'h00, 4'd7,  8'h00, 4'd6}, // addressed but not enabled
        '{1'b1, 4'd0,  8'h00, 4'd2,  8'h00, 4'd6},
        '{1'b0, 4'd15, 8'hAA, 4'd15, 8'hAA, 4'd7}, // R7
        '{1'b1, 4'd0,  8'h00, 4'd0,  8'h3C, 4'd7},
        '{1'b0, 4'd14, 8'h00, 4'd14, 8'h01, 4'd3}, // bit0 masked off
        '{1'b0, 4'd15, 8'hFF, 4'd15, 8'hFF, 4'd4},
        '{1'b0, 4'd14, 8'h00, 4'd14, 8'h00, 4'd5},
        '{1'b0, 4'd2,  8'h77, 4'd2,  8'h77, 4'd6}, // broadcast off
        '{1'b1, 4'd0,  8'h00, 4'd0,  8'h3C, 4'd6}
    };

    function automatic logic [7:0] bank_of(input int b);
        if (b < NCH)       return chan[b*8 +: 8];
        else if (b < 15)   return glob[(b-12)*8 +: 8];
        else               return mask;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_n = 1'b0; addr = a; data = d;
        @(negedge clk);
        wr_n = 1'b1;
    endtask

    task automatic check_defaults(input string tag);
        check({tag, " R1 chan"}, 128'(chan), 128'(0));
        check({tag, " R1 glob"}, 128'(glob), 128'(24'h000FFF));
        check({tag, " R1 mask"}, 128'(mask), 128'(8'hFF));
    endtask

    initial begin
        logic [8*NCH-1:0] snap;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_defaults("start"); // R1

        for (int i = 0; i < NV; i++) begin
            wr_n = VECS[i].wr_n; addr = VECS[i].addr; data = VECS[i].data;
            @(negedge clk);
            wr_n = 1'b1;
            check($sformatf("R%0d vec %0d bank %0d", VECS[i].req, i, VECS[i].bank),
                  128'(bank_of(int'(VECS[i].bank))), 128'(VECS[i].exp));
        end

        // R6: broadcast with empty group enable touches nothing
        wr(4'd12, 8'h00);
        wr(4'd13, 8'h00);
        wr(4'd14, 8'h01);
        snap = chan;
        wr(4'd4, 8'hEE);
        check("R6 empty group", 128'(chan), 128'(snap));

        // R7: global write under broadcast leaves channels
        wr(4'd12, 8'hFF);
        snap = chan;
        wr(4'd13, 8'h0F);
        check("R7 global under broadcast", 128'(chan), 128'(snap));
        wr(4'd5, 8'h99);
        check("R6 full group", 128'(chan), {NCH{8'h99}});

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_defaults("mid");

        // R8: gap addresses on the small instance
        wr(4'd9, 8'hFF);
        wr(4'd10, 8'hFF);
        wr(4'd8, 8'hFF);
        check("R8 small chan", 128'(s_chan), 128'(0));
        check("R8 small glob", 128'(s_glob), 128'(24'h000FFF));
        check("R8 small mask", 128'(s_mask), 128'(8'hFF));
        wr(4'd7, 8'h42);
        check("R5 small top bank", 128'(s_chan[63:56]), 128'(8'h42));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule